// File: doc/BRIEF.md
# Instruction Prefetch Sequencer

This block sits between program memory and the execute stage of a core with 24-bit instructions. It keeps one fetch running ahead of execution. The word fetched last waits in the output register of a synchronous program memory, which serves as the prefetch buffer. The sequencer tracks the address of that word and moves it into an instruction register when the current instruction retires. It drives the fetch address and fetch enable, and it presents the executing instruction with a valid flag and a flag that marks a second execution cycle.

A decoder outside the block looks at the presented instruction. In the same cycle it returns four class flags: taken flow change, program-space operand, double-word move, and executing-inside-a-repeat-loop. For a taken flow change the decoder also returns a target address. From these flags the sequencer decides whether the instruction retires after one cycle or two. On a taken flow change it discards the instruction register and the prefetch buffer and refetches from the target. An external stall request freezes everything.

The controller has four named states. `ST_BOOT` holds after reset with nothing fetched. `ST_REFILL` is a bubble with the prefetch buffer full and the instruction register empty. `ST_RUN` is the first or only cycle of a valid instruction. `ST_SECOND` is the extra cycle of a two-cycle instruction.

The transitions are:
- BOOT→REFILL: first fetch.
- REFILL→RUN: load.
- RUN→RUN: single-cycle retire.
- RUN→SECOND: two-cycle class.
- RUN→REFILL: flush.
- SECOND→RUN: retire.
- Any state to itself: stall.

Top module: `prefetch_ctl`

## Requirements
- R1: In the first cycle after reset is released, ir_valid is 0, imem_en is 1 and imem_addr is 0. The next cycle is also a bubble and fetches address 2. In the third cycle, the word at address 0 is valid in the instruction register with ir_addr 0.
- R2: Each sequential fetch advances the address by 2. In steady single-cycle flow, ir_addr steps by 2 every cycle, imem_addr equals ir_addr + 4, and ir_word is the memory word at ir_addr.
- R3: A valid instruction in its first cycle with cls_flow high and no stall fetches flow_target in that cycle. The following cycle is exactly one bubble (ir_valid 0). The cycle after that presents the word at flow_target, with ir_addr equal to flow_target.
- R4: A double-word move (cls_dword) takes two cycles. In the second cycle, ir_second is 1 and ir_addr is unchanged. The double-word move stays two cycles inside a repeat loop.
- R5: A program-space operand instruction (cls_psv) outside a repeat loop takes two cycles.
- R6: A program-space operand instruction with cls_in_rep high takes one cycle. cls_in_rep alone does not change the instruction length.
- R7: While stall_req is high, imem_en is 0, and ir_addr, ir_valid, ir_second and imem_addr hold their values.
- R8: Class flags have no effect during a bubble or during the second cycle of a two-cycle instruction.
- R9: A flow change takes priority over the two-cycle flags: cls_flow with cls_dword flushes and never enters a second cycle.
- R10: A flow change that is stalled is not taken until the stall drops. The target used is the one present in the cycle the stall releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 1 | Freeze request from the pipeline |
| cls_flow | input | 1 | Decoder: presented instruction is a taken flow change |
| cls_psv | input | 1 | Decoder: presented instruction reads an operand from program space |
| cls_dword | input | 1 | Decoder: presented instruction is a double-word move |
| cls_in_rep | input | 1 | Decoder: instruction executes inside a repeat loop |
| flow_target | input | ADDR_W | Target address of a taken flow change |
| imem_rdata | input | INSTR_W | Program memory registered read data (prefetch buffer) |
| imem_en | output | 1 | Program memory fetch enable |
| imem_addr | output | ADDR_W | Program memory fetch address |
| ir_word | output | INSTR_W | Instruction register contents |
| ir_addr | output | ADDR_W | Address of the presented instruction |
| ir_valid | output | 1 | Presented instruction is real (low during bubbles) |
| ir_second | output | 1 | Second cycle of a two-cycle instruction |

## Verification
The hardest situations to reach are the ones where class flags arrive while the instruction register does not hold a fresh first cycle. Examples are a flow change during the refill bubble, or one during the second cycle of a double-word move. Another is a flow change held under stall while its target changes. The decoder is not a real one: the bench plays it, so it can raise any flag combination in any chosen cycle. It then confirms, from the address and word that come out next, that the flags were ignored or deferred.

// File: rtl/prefetch_ctl_pkg.sv
package prefetch_ctl_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_REFILL = 2'd1,
        ST_RUN    = 2'd2,
        ST_SECOND = 2'd3
    } pf_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_SEQ      = 2'd1,
        ACT_REDIRECT = 2'd2
    } fetch_act_e;

    typedef struct packed {
        logic flow;
        logic psv;
        logic dword;
        logic in_rep;
    } ins_class_t;

endpackage

// File: rtl/prefetch_ctl_fsm.sv
module prefetch_ctl_fsm
    import prefetch_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall_req,
    input  ins_class_t cls,
    output fetch_act_e fetch_act,
    output logic       load_ir,
    output logic       ir_valid,
    output logic       ir_second
);

    pf_state_e state_q;
    pf_state_e state_d;
    logic      two_cycle;

    // program-space operands are free inside a repeat loop; double-word moves never are
    assign two_cycle = cls.dword | (cls.psv & ~cls.in_rep);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (!stall_req) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (!stall_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!stall_req) begin
                    if (cls.flow)      state_d = ST_REFILL;
                    else if (two_cycle) state_d = ST_SECOND;
                    else               state_d = ST_RUN;
                end
            end
            ST_SECOND: begin
                if (!stall_req) state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        fetch_act = ACT_HOLD;
        load_ir   = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                if (!stall_req) fetch_act = ACT_SEQ;
            end
            ST_REFILL: begin
                if (!stall_req) begin
                    fetch_act = ACT_SEQ;
                    load_ir   = 1'b1;
                end
            end
            ST_RUN: begin
                if (!stall_req) begin
                    if (cls.flow) begin
                        fetch_act = ACT_REDIRECT;
                    end else if (!two_cycle) begin
                        fetch_act = ACT_SEQ;
                        load_ir   = 1'b1;
                    end
                end
            end
            ST_SECOND: begin
                if (!stall_req) begin
                    fetch_act = ACT_SEQ;
                    load_ir   = 1'b1;
                end
            end
        endcase
    end

    assign ir_valid  = (state_q == ST_RUN) || (state_q == ST_SECOND);
    assign ir_second = (state_q == ST_SECOND);

endmodule

// File: rtl/prefetch_ctl_pc.sv
module prefetch_ctl_pc
    import prefetch_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PC_STEP  = 2,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fetch_act_e        fetch_act,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] pfb_addr
);

    localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(PC_STEP);
    localparam logic [ADDR_W-1:0] RESET_V = ADDR_W'(RESET_PC);

    logic [ADDR_W-1:0] pc_q;

    assign fetch_addr = (fetch_act == ACT_REDIRECT) ? target : pc_q;
    assign fetch_en   = (fetch_act != ACT_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_V;
            pfb_addr <= RESET_V;
        end else if (fetch_en) begin
            pc_q     <= fetch_addr + STEP_V;
            pfb_addr <= fetch_addr;
        end
    end

endmodule

// File: rtl/prefetch_ctl_ir.sv
module prefetch_ctl_ir #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [INSTR_W-1:0] buf_word,
    input  logic [ADDR_W-1:0]  buf_addr,
    output logic [INSTR_W-1:0] ir_word,
    output logic [ADDR_W-1:0]  ir_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_word <= '0;
            ir_addr <= '0;
        end else if (load) begin
            ir_word <= buf_word;
            ir_addr <= buf_addr;
        end
    end

endmodule

// File: rtl/prefetch_ctl.sv
module prefetch_ctl
    import prefetch_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned INSTR_W  = 24,
    parameter int unsigned PC_STEP  = 2,
    parameter int unsigned RESET_PC = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_req,
    input  logic               cls_flow,
    input  logic               cls_psv,
    input  logic               cls_dword,
    input  logic               cls_in_rep,
    input  logic [ADDR_W-1:0]  flow_target,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               imem_en,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [INSTR_W-1:0] ir_word,
    output logic [ADDR_W-1:0]  ir_addr,
    output logic               ir_valid,
    output logic               ir_second
);

    ins_class_t        cls;
    fetch_act_e        fetch_act;
    logic              load_ir;
    logic [ADDR_W-1:0] pfb_addr;

    assign cls = '{flow: cls_flow, psv: cls_psv, dword: cls_dword, in_rep: cls_in_rep};

    prefetch_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_req (stall_req),
        .cls       (cls),
        .fetch_act (fetch_act),
        .load_ir   (load_ir),
        .ir_valid  (ir_valid),
        .ir_second (ir_second)
    );

    prefetch_ctl_pc #(
        .ADDR_W   (ADDR_W),
        .PC_STEP  (PC_STEP),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_act  (fetch_act),
        .target     (flow_target),
        .fetch_addr (imem_addr),
        .fetch_en   (imem_en),
        .pfb_addr   (pfb_addr)
    );

    prefetch_ctl_ir #(
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W)
    ) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ir),
        .buf_word (imem_rdata),
        .buf_addr (pfb_addr),
        .ir_word  (ir_word),
        .ir_addr  (ir_addr)
    );

endmodule

// File: rtl/prefetch_ctl_chk.sv
module prefetch_ctl_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_req,
    input logic              cls_flow,
    input logic              cls_psv,
    input logic              cls_dword,
    input logic              cls_in_rep,
    input logic [ADDR_W-1:0] flow_target,
    input logic              imem_en,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [ADDR_W-1:0] ir_addr,
    input logic              ir_valid,
    input logic              ir_second
);

    logic first_cyc;
    assign first_cyc = ir_valid && !ir_second && !stall_req;

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cyc && !cls_flow && !cls_dword && !cls_psv)
        |=> (ir_valid && ir_addr == $past(ir_addr) + ADDR_W'(2)));

    assert_bubble_after_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cyc && cls_flow) |=> !ir_valid);

    assert_target_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cyc && cls_flow) |-> (imem_en && imem_addr == flow_target));

    assert_second_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cyc && !cls_flow && cls_dword) |=> (ir_second && $stable(ir_addr)));

    assert_second_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ir_second |-> ir_valid);

    assert_rep_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cyc && !cls_flow && !cls_dword && cls_psv && cls_in_rep) |=> !ir_second);

    assert_no_fetch_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> !imem_en);

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> ($stable(ir_addr) && $stable(ir_valid) && $stable(ir_second)));

endmodule

bind prefetch_ctl prefetch_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_req   (stall_req),
    .cls_flow    (cls_flow),
    .cls_psv     (cls_psv),
    .cls_dword   (cls_dword),
    .cls_in_rep  (cls_in_rep),
    .flow_target (flow_target),
    .imem_en     (imem_en),
    .imem_addr   (imem_addr),
    .ir_addr     (ir_addr),
    .ir_valid    (ir_valid),
    .ir_second   (ir_second)
);

// File: tb/prefetch_ctl_tb_top.sv
module prefetch_ctl_tb_top;

    localparam int AW = 16;
    localparam int IW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stall_req, cls_flow, cls_psv, cls_dword, cls_in_rep;
    logic [AW-1:0] flow_target;
    logic [IW-1:0] imem_rdata;
    logic          imem_en;
    logic [AW-1:0] imem_addr;
    logic [IW-1:0] ir_word;
    logic [AW-1:0] ir_addr;
    logic          ir_valid, ir_second;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic          cur_en;
    logic [AW-1:0] cur_addr;

    always #10 clk = ~clk;

    prefetch_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .stall_req(stall_req),
        .cls_flow(cls_flow), .cls_psv(cls_psv), .cls_dword(cls_dword),
        .cls_in_rep(cls_in_rep), .flow_target(flow_target),
        .imem_rdata(imem_rdata), .imem_en(imem_en), .imem_addr(imem_addr),
        .ir_word(ir_word), .ir_addr(ir_addr), .ir_valid(ir_valid),
        .ir_second(ir_second)
    );

    function automatic logic [IW-1:0] rom_word(input logic [AW-1:0] a);
        return {a[8:1] ^ 8'h5A, a};
    endfunction

    always_ff @(posedge clk) if (imem_en) imem_rdata <= rom_word(imem_addr);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        stall_req = 0; cls_flow = 0; cls_psv = 0; cls_dword = 0; cls_in_rep = 0;
        flow_target = '0;
    endtask

    // drive flags for the current cycle, record its fetch, move to the next cycle
    task automatic cyc(input logic f, input logic p, input logic d, input logic r,
                       input logic s, input logic [AW-1:0] tgt);
        cls_flow = f; cls_psv = p; cls_dword = d; cls_in_rep = r;
        stall_req = s; flow_target = tgt;
        #1;
        cur_en = imem_en; cur_addr = imem_addr;
        @(negedge clk);
        clear_in();
        #1;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    task automatic boot();
        do_reset();
        cyc(0,0,0,0,0,0);
        cyc(0,0,0,0,0,0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "boot valid", ir_valid, 0);
        chk("R1", "boot en", imem_en, 1);
        chk("R1", "boot addr", imem_addr, 0);
        cyc(0,0,0,0,0,0);
        chk("R1", "refill valid", ir_valid, 0);
        chk("R1", "refill addr", imem_addr, 2);
        cyc(0,0,0,0,0,0);
        chk("R1", "first valid", ir_valid, 1);
        chk("R1", "first ir_addr", ir_addr, 0);
        chk("R1", "first word", ir_word, rom_word(0));
    endtask

    task automatic t_sequential();
        boot();
        for (int i = 1; i <= 4; i++) begin
            cyc(0,0,0,0,0,0);
            chk("R2", "ir_addr", ir_addr, 2 * i);
            chk("R2", "word", ir_word, rom_word(AW'(2 * i)));
            chk("R2", "fetch ahead", imem_addr, 2 * i + 4);
        end
    endtask

    task automatic t_flow();
        boot();
        cyc(1,0,0,0,0,16'h0040);
        chk("R3", "target fetch", cur_addr, 16'h0040);
        chk("R3", "target en", cur_en, 1);
        chk("R3", "bubble", ir_valid, 0);
        cyc(1,0,1,0,0,16'h0080);       // R8: flags during bubble ignored
        chk("R8", "bubble flags ignored", ir_addr, 16'h0040);
        chk("R3", "target valid", ir_valid, 1);
        chk("R3", "target word", ir_word, rom_word(16'h0040));
        chk("R8", "no second", ir_second, 0);
        cyc(1,0,0,0,0,16'h0010);       // back-to-back flow change
        chk("R3", "second bubble", ir_valid, 0);
        cyc(0,0,0,0,0,0);
        chk("R3", "second target", ir_addr, 16'h0010);
        cyc(0,0,0,0,0,0);
        chk("R3", "after target", ir_addr, 16'h0012);
    endtask

    task automatic t_dword();
        boot();
        cyc(0,0,1,0,0,0);
        chk("R4", "second flag", ir_second, 1);
        chk("R4", "addr held", ir_addr, 0);
        chk("R4", "no fetch", cur_en, 0);
        cyc(1,0,0,0,0,16'h0100);       // R8: flow in second cycle ignored
        chk("R8", "second flow ignored", ir_addr, 2);
        chk("R8", "valid", ir_valid, 1);
        chk("R4", "second ends", ir_second, 0);
    endtask

    task automatic t_psv();
        boot();
        cyc(0,1,0,0,0,0);
        chk("R5", "psv second", ir_second, 1);
        chk("R5", "psv addr", ir_addr, 0);
        cyc(0,0,0,0,0,0);
        chk("R5", "psv retire", ir_addr, 2);
    endtask

    task automatic t_psv_rep();
        boot();
        cyc(0,1,0,1,0,0);
        chk("R6", "rep psv single", ir_second, 0);
        chk("R6", "rep psv addr", ir_addr, 2);
        cyc(0,0,0,1,0,0);
        chk("R6", "rep alone", ir_addr, 4);
        cyc(0,0,1,1,0,0);
        chk("R4", "dword in rep", ir_second, 1);
    endtask

    task automatic t_stall();
        boot();
        cyc(0,0,0,0,1,0);
        chk("R7", "stall addr", ir_addr, 0);
        chk("R7", "stall valid", ir_valid, 1);
        chk("R7", "stall no fetch", cur_en, 0);
        chk("R7", "stall pc", imem_addr, 4);
        cyc(0,0,1,0,1,0);
        chk("R7", "stalled dword", ir_second, 0);
        cyc(0,0,1,0,0,0);
        cyc(0,0,0,0,1,0);
        chk("R7", "stall in second", ir_second, 1);
        chk("R7", "second addr", ir_addr, 0);
        cyc(0,0,0,0,0,0);
        chk("R7", "release", ir_addr, 2);
        chk("R7", "word after", ir_word, rom_word(2));
    endtask

    task automatic t_flow_dword();
        boot();
        cyc(1,0,1,0,0,16'h0020);
        chk("R9", "flush", ir_valid, 0);
        chk("R9", "no second", ir_second, 0);
        cyc(0,0,0,0,0,0);
        chk("R9", "target", ir_addr, 16'h0020);
    endtask

    task automatic t_flow_stall();
        boot();
        cyc(1,0,0,0,1,16'h0060);
        chk("R10", "held valid", ir_valid, 1);
        chk("R10", "held addr", ir_addr, 0);
        chk("R10", "no fetch", cur_en, 0);
        cyc(1,0,0,0,0,16'h0070);
        chk("R10", "late fetch", cur_addr, 16'h0070);
        chk("R10", "bubble", ir_valid, 0);
        cyc(0,0,0,0,0,0);
        chk("R10", "released target", ir_addr, 16'h0070);
    endtask

    initial begin
        clear_in();
        rst_n = 0;
        t_reset();
        t_sequential();
        t_flow();
        t_dword();
        t_psv();
        t_psv_rep();
        t_stall();
        t_flow_dword();
        t_flow_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule